// File: doc/BRIEF.md
# Patch Difference Correlation Matcher

This block pairs up corner features found in two consecutive video frames. It holds two feature lists of (x, y) coordinates in two banks, and a select input says which bank holds the earlier frame. A scan visits every earlier-frame feature in index order. For each one it walks the later-frame features in index order. A pair goes on to scoring only when the two points lie within a bounded displacement of each other on both axes.

Scoring a pair takes two window fetches through a request/response pixel port. The first fetch loads the square window around the earlier feature into a patch register. The second fetch streams the window around the later feature and folds each arriving pixel into a running sum of absolute differences. A single subtract-and-accumulate path does this work, so the logic does not grow with the window size. A pair is accepted only when its score is strictly below a programmable threshold. Each earlier-frame feature keeps only its lowest-scoring accepted partner. That winner is written into a bounded match buffer, which can be read back through a combinational read port.

Top module: `patch_sad_matcher`

## Requirements
- R1: A pair is fetched and scored only when both |xb - xa| <= MAXD and |yb - ya| <= MAXD (MAXD defaults to 17). Pairs outside this window issue no pixel requests and are never stored.
- R2: Scoring a candidate pair issues exactly 2*WIN*WIN pixel requests. First come WIN*WIN requests with pix_frame=0, centred on the earlier feature in raster order (x fastest, starting at offset -WIN/2). Then come WIN*WIN requests with pix_frame=1, centred on the later feature in the same order.
- R3: The score is the sum over the window of |later pixel - earlier pixel| at equal offsets. A pair is accepted only if score < thr, so a score equal to thr is rejected.
- R4: Among the accepted partners of one earlier feature, only the one with the lowest score is kept. On a tie, the lower later-feature index wins.
- R5: Matches are written in order of earlier-feature index. Entry k reads back as rd_a = earlier-feature index and rd_b = later-feature index. match_cnt counts the stored entries.
- R6: Once MD entries are stored, full is 1 and any further matches are dropped without changing match_cnt.
- R7: At the end of a scan, done is high for exactly one cycle and busy falls. A start seen while busy is ignored. A scan with cnt_a = 0 finishes with no pixel requests and no matches.
- R8: prev_bank selects the bank that holds the earlier frame. The other bank holds the later frame.
- R9: After reset, busy, done, pix_req, full are 0 and match_cnt is 0. A new accepted start clears match_cnt and full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| feat_we | input | 1 | Feature write strobe |
| feat_bank | input | 1 | Bank written by the strobe |
| feat_addr | input | FIW | Feature index written |
| feat_x | input | CW | Feature x coordinate |
| feat_y | input | CW | Feature y coordinate |
| start | input | 1 | Begin a scan (ignored while busy) |
| prev_bank | input | 1 | Bank holding the earlier frame |
| cnt_a | input | FIW+1 | Number of earlier-frame features |
| cnt_b | input | FIW+1 | Number of later-frame features |
| thr | input | SW | Acceptance threshold (strict) |
| pix_req | output | 1 | Pixel request |
| pix_frame | output | 1 | 0 = earlier frame, 1 = later frame |
| pix_x | output | CW | Requested pixel x |
| pix_y | output | CW | Requested pixel y |
| pix_vld | input | 1 | Pixel response valid (in request order) |
| pix_data | input | PW | Pixel value (unsigned fixed point) |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle end-of-scan pulse |
| match_cnt | output | MIW+1 | Stored match count |
| full | output | 1 | Match buffer full |
| rd_addr | input | MIW | Match buffer read index |
| rd_a | output | FIW | Earlier-frame feature index of the entry |
| rd_b | output | FIW | Later-frame feature index of the entry |

## Verification
Some properties are checked on every cycle by assertions:
- done never lasts two cycles.
- The match count cannot move once the buffer is full.
- Within one earlier feature, the running best score never rises.
- Any entry about to be written scored below the threshold.
- No pixel is requested while idle.

Other behaviour only the bench's scenarios can show. This covers the displacement gate at exactly 17 and 18 pixels, the request count per candidate, the exact difference sums against an arithmetic image model, and the strict threshold at equality. It also covers bank swapping, the dropping of overflow matches, and a start ignored mid-scan.

// File: rtl/patch_sad_matcher.sv
module patch_sad_matcher #(
  parameter int CW   = 10,
  parameter int PW   = 25,
  parameter int WIN  = 11,
  parameter int MAXD = 17,
  parameter int NF   = 16,
  parameter int MD   = 512,
  parameter int FIW  = $clog2(NF),
  parameter int MIW  = $clog2(MD),
  parameter int SW   = PW + $clog2(WIN*WIN) + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           feat_we,
  input  logic           feat_bank,
  input  logic [FIW-1:0] feat_addr,
  input  logic [CW-1:0]  feat_x,
  input  logic [CW-1:0]  feat_y,
  input  logic           start,
  input  logic           prev_bank,
  input  logic [FIW:0]   cnt_a,
  input  logic [FIW:0]   cnt_b,
  input  logic [SW-1:0]  thr,
  output logic           pix_req,
  output logic           pix_frame,
  output logic [CW-1:0]  pix_x,
  output logic [CW-1:0]  pix_y,
  input  logic           pix_vld,
  input  logic [PW-1:0]  pix_data,
  output logic           busy,
  output logic           done,
  output logic [MIW:0]   match_cnt,
  output logic           full,
  input  logic [MIW-1:0] rd_addr,
  output logic [FIW-1:0] rd_a,
  output logic [FIW-1:0] rd_b
);
  localparam int N   = WIN * WIN;
  localparam int H   = WIN / 2;
  localparam int NW  = $clog2(N + 1);
  localparam int CLW = $clog2(WIN);
  localparam logic signed [CW:0] LIM = MAXD;

  typedef enum logic [2:0] {IDLE, PAIR, LOADA, LOADB, EVAL, NEXTA} st_t;
  st_t st;

  logic [CW-1:0]    fx [2][NF];
  logic [CW-1:0]    fy [2][NF];
  logic [PW-1:0]    patch [N];
  logic [2*FIW-1:0] mbuf [MD];

  logic [FIW:0]   ia, jb, la, lb;
  logic           pb, have;
  logic [NW-1:0]  rq, rs;
  logic [CLW-1:0] col, row;
  logic [SW-1:0]  acc, best;
  logic [FIW-1:0] bestj;
  logic [MIW:0]   mcnt;

  wire [CW-1:0] ax = fx[pb][ia[FIW-1:0]];
  wire [CW-1:0] ay = fy[pb][ia[FIW-1:0]];
  wire [CW-1:0] bx = fx[~pb][jb[FIW-1:0]];
  wire [CW-1:0] by = fy[~pb][jb[FIW-1:0]];
  wire signed [CW:0] dx = $signed({1'b0, bx}) - $signed({1'b0, ax});
  wire signed [CW:0] dy = $signed({1'b0, by}) - $signed({1'b0, ay});
  wire near = (dx <= LIM) && (dx >= -LIM) && (dy <= LIM) && (dy >= -LIM);

  wire loading = (st == LOADA) || (st == LOADB);
  assign pix_req   = loading && (rq < NW'(N));
  assign pix_frame = (st == LOADB);
  assign pix_x = ((st == LOADB) ? bx : ax) - CW'(H) + CW'(col);
  assign pix_y = ((st == LOADB) ? by : ay) - CW'(H) + CW'(row);

  wire signed [PW:0] df = $signed({1'b0, pix_data}) - $signed({1'b0, patch[rs]});
  wire [PW:0] ad = df[PW] ? (PW+1)'(-df) : (PW+1)'(df);
  wire last_rsp = pix_vld && (rs == NW'(N - 1));

  assign busy      = (st != IDLE);
  assign match_cnt = mcnt;
  assign full      = (mcnt == (MIW+1)'(MD));
  assign {rd_a, rd_b} = mbuf[rd_addr];

  always_ff @(posedge clk) begin
    if (feat_we) begin
      fx[feat_bank][feat_addr] <= feat_x;
      fy[feat_bank][feat_addr] <= feat_y;
    end
    if (st == LOADA && pix_vld) patch[rs] <= pix_data;
    if (st == NEXTA && have && !full) mbuf[mcnt[MIW-1:0]] <= {ia[FIW-1:0], bestj};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; done <= 1'b0; ia <= '0; jb <= '0; la <= '0; lb <= '0;
      pb <= 1'b0; have <= 1'b0; rq <= '0; rs <= '0; col <= '0; row <= '0;
      acc <= '0; best <= '0; bestj <= '0; mcnt <= '0;
    end else begin
      done <= 1'b0;
      if (pix_req) begin
        rq <= rq + 1'b1;
        if (col == CLW'(WIN - 1)) begin col <= '0; row <= row + 1'b1; end
        else col <= col + 1'b1;
      end
      if (loading && pix_vld) rs <= rs + 1'b1;
      case (st)
        IDLE: if (start) begin
          la <= cnt_a; lb <= cnt_b; pb <= prev_bank;
          ia <= '0; jb <= '0; have <= 1'b0; mcnt <= '0; st <= PAIR;
        end
        PAIR: begin
          rq <= '0; rs <= '0; col <= '0; row <= '0; acc <= '0;
          if (ia == la) begin done <= 1'b1; st <= IDLE; end
          else if (jb == lb) st <= NEXTA;
          else if (near) st <= LOADA;
          else jb <= jb + 1'b1;
        end
        LOADA: if (last_rsp) begin
          st <= LOADB; rq <= '0; rs <= '0; col <= '0; row <= '0;
        end
        LOADB: begin
          if (pix_vld) acc <= acc + SW'(ad);
          if (last_rsp) st <= EVAL;
        end
        EVAL: begin
          if (acc < thr && (!have || acc < best)) begin
            best <= acc; bestj <= jb[FIW-1:0]; have <= 1'b1;
          end
          jb <= jb + 1'b1; st <= PAIR;
        end
        NEXTA: begin
          if (have && !full) mcnt <= mcnt + 1'b1;
          ia <= ia + 1'b1; jb <= '0; have <= 1'b0; st <= PAIR;
        end
        default: st <= IDLE;
      endcase
    end
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && st != IDLE) |=> $stable(mcnt));
  // R3
  accept_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == NEXTA && have) |-> (best < thr));
  // R4
  best_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == EVAL && have) |=> (best <= $past(best)));
  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !pix_req);
endmodule

// File: tb/patch_sad_matcher_tb_top.sv
module patch_sad_matcher_tb_top;
  localparam int CW = 10, PW = 25, WIN = 11, MAXD = 17, NF = 6, MD = 4;
  localparam int FIW = $clog2(NF), MIW = $clog2(MD);
  localparam int SW = PW + $clog2(WIN*WIN) + 1;
  localparam int N = WIN*WIN, H = WIN/2;

  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic feat_we = 0, feat_bank = 0, start = 0, prev_bank = 0;
  logic [FIW-1:0] feat_addr = '0;
  logic [CW-1:0] feat_x = '0, feat_y = '0;
  logic [FIW:0] cnt_a = '0, cnt_b = '0;
  logic [SW-1:0] thr = '0;
  logic pix_req, pix_frame, pix_vld = 0, busy, done, full;
  logic [CW-1:0] pix_x, pix_y;
  logic [PW-1:0] pix_data = '0;
  logic [MIW:0] match_cnt;
  logic [MIW-1:0] rd_addr = '0;
  logic [FIW-1:0] rd_a, rd_b;

  patch_sad_matcher #(.CW(CW), .PW(PW), .WIN(WIN), .MAXD(MAXD), .NF(NF), .MD(MD)) dut_i (
    .clk, .rst_n, .feat_we, .feat_bank, .feat_addr, .feat_x, .feat_y,
    .start, .prev_bank, .cnt_a, .cnt_b, .thr, .pix_req, .pix_frame, .pix_x, .pix_y,
    .pix_vld, .pix_data, .busy, .done, .match_cnt, .full, .rd_addr, .rd_a, .rd_b);

  int checks = 0, errs = 0, reqs = 0, dones = 0, cyc = 0;
  int bx0 [2][NF], by0 [2][NF];
  int ecnt, ea [MD], eb [MD], ereq;

  function automatic int img(int f, int x, int y);
    int xm = x & 1023, ym = y & 1023;
    if (f == 0) return (xm*37 + ym*91 + ((xm*ym) % 17)*5) % 1000;
    return img(0, xm - 4, ym + 2) + ((xm*3 + ym) % 5);
  endfunction

  function automatic int sad(int ax, int ay, int bx, int by);
    int s = 0;
    for (int v = -H; v <= H; v++)
      for (int u = -H; u <= H; u++) begin
        int d = img(1, bx+u, by+v) - img(0, ax+u, ay+v);
        s += (d < 0) ? -d : d;
      end
    return s;
  endfunction

  always @(posedge clk) begin
    pix_vld  <= pix_req;
    pix_data <= PW'(img(pix_frame ? 1 : 0, int'(pix_x), int'(pix_y)));
    if (pix_req) reqs <= reqs + 1;
    if (done) dones <= dones + 1;
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      errs = errs + 1;
      $display("FAIL watchdog: expired, actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
      $finish;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(int b, int a, int x, int y);
    @(negedge clk);
    feat_we = 1; feat_bank = b[0]; feat_addr = FIW'(a); feat_x = CW'(x); feat_y = CW'(y);
    bx0[b][a] = x; by0[b][a] = y;
    @(negedge clk);
    feat_we = 0;
  endtask

  task automatic model(int pb, int na, int nb, int t);
    ecnt = 0; ereq = 0;
    for (int i = 0; i < na; i++) begin
      int best = 0, bj = 0; bit hv = 0;
      for (int j = 0; j < nb; j++) begin
        int ax = bx0[pb][i], ay = by0[pb][i], bx = bx0[1-pb][j], by = by0[1-pb][j];
        if ((bx-ax) <= MAXD && (ax-bx) <= MAXD && (by-ay) <= MAXD && (ay-by) <= MAXD) begin
          int s = sad(ax, ay, bx, by);
          ereq += 2*N;
          if (s < t && (!hv || s < best)) begin best = s; bj = j; hv = 1; end
        end
      end
      if (hv && ecnt < MD) begin ea[ecnt] = i; eb[ecnt] = bj; ecnt++; end
    end
  endtask

  task automatic run(string tag, int pb, int na, int nb, int t, bit poke);
    int d0;
    model(pb, na, nb, t);
    @(negedge clk);
    reqs = 0; d0 = dones;
    prev_bank = pb[0]; cnt_a = (FIW+1)'(na); cnt_b = (FIW+1)'(nb); thr = SW'(t); start = 1;
    @(negedge clk);
    start = 0;
    if (poke) begin
      repeat (50) @(negedge clk);
      cnt_a = '0; prev_bank = ~prev_bank; start = 1;   // R7: ignored while busy
      @(negedge clk);
      start = 0;
    end
    while (!done) @(negedge clk);
    @(negedge clk);
    chk({tag, " R7 busy low after done"}, int'(busy), 0);
    chk({tag, " R7 single done"}, dones - d0, 1);
    chk({tag, " R2 R1 request count"}, reqs, ereq);
    chk({tag, " R5 match_cnt"}, int'(match_cnt), ecnt);
    chk({tag, " R6 full"}, int'(full), (ecnt == MD) ? 1 : 0);
    for (int k = 0; k < ecnt; k++) begin
      rd_addr = MIW'(k);
      #1;
      chk({tag, " R5 R8 entry a"}, int'(rd_a), ea[k]);
      chk({tag, " R4 R3 entry b"}, int'(rd_b), eb[k]);
    end
  endtask

  initial begin
    #1;
    chk("R9 busy at reset", int'(busy), 0);
    chk("R9 pix_req at reset", int'(pix_req), 0);
    chk("R9 match_cnt at reset", int'(match_cnt), 0);
    chk("R9 full at reset", int'(full), 0);
    chk("R9 done at reset", int'(done), 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    wr(0,0, 20,20);  wr(0,1, 40,30);  wr(0,2, 100,100);
    wr(0,3, 60,60);  wr(0,4, 200,50); wr(0,5, 300,300);
    wr(1,0, 24,18);  wr(1,1, 118,100); wr(1,2, 44,28);
    wr(1,3, 117,100); wr(1,4, 64,58); wr(1,5, 204,48);
    run("s1 R1 three features", 0, 3, 6, 32'h7fffffff, 0);
    run("s2 R6 overflow", 0, 6, 6, 32'h7fffffff, 0);
    run("s3 R3 threshold equal", 0, 6, 6, sad(20,20,24,18), 0);
    run("s4 R3 tight threshold", 0, 4, 6, sad(40,30,44,28) + 1, 0);
    run("s5 R8 swapped banks", 1, 6, 6, 32'h7fffffff, 0);
    run("s6 R7 empty scan", 0, 0, 6, 32'h7fffffff, 0);
    run("s7 R7 start while busy", 0, 3, 6, 32'h7fffffff, 1);
    wr(1,3, 100,117);
    wr(1,1, 100,118);
    run("s8 R1 y boundary", 0, 3, 6, 32'h7fffffff, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end
endmodule